// File: doc/BRIEF.md
# Eight-Way Addressable Output Latch with Decoder Mode

This block keeps eight driver-gate control bits, one for each output of an open-drain sink stage. A 3-bit select input picks one of the eight positions, and a single data input supplies the value for that position. Two active-low controls, a clear and an enable, choose one of four operating modes:

- **Addressable write:** only the selected position takes the data bit.
- **Hold:** the stored pattern is frozen.
- **Decoder / demultiplexer:** the selected position follows the data bit and every other position is forced off.
- **Global off:** every driver is turned off.

All updates happen on the rising clock edge. An asynchronous active-low reset turns every driver off at once. A drive bit of 1 means the sink transistor conducts, so the modelled pin level is the inverse of the drive bit.

A host can use the block in three ways:

- as a bank of individually settable relay or solenoid controls, written one bit at a time in addressable-write mode and then parked in hold mode;
- as a 3-to-8 decoder, by holding the data input high in decoder mode;
- as a one-line-to-eight demultiplexer.

Top module: `adl_latch8`

## Requirements
- R1: Select value k (bit 0 is the least significant) addresses output position k, so it affects `sink_on[k]` and `pad_level[k]`.
- R2: With `clr_n`=1 and `en_n`=0 (addressable write), at each rising edge the addressed drive bit takes the value of `din`. A 1 turns the sink on.
- R3: In addressable-write mode, every position that is not addressed keeps its previous drive bit across the edge.
- R4: With `clr_n`=1 and `en_n`=1 (hold), all eight drive bits stay unchanged at each edge, whatever `sel` and `din` are.
- R5: With `clr_n`=0 and `en_n`=1 (global off), every drive bit is 0 after the next rising edge.
- R6: With `clr_n`=0 and `en_n`=0 (decoder mode), after the edge the addressed drive bit equals `din` and all other drive bits are 0.
- R7: `pad_level` is always the bitwise inverse of `sink_on`. A conducting sink reads as a low pin.
- R8: While `rst_n` is low, all drive bits are 0. This takes effect without waiting for a clock edge.
- R9: After global-off mode, switching to hold mode keeps all drive bits at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; all drivers off |
| sel | input | 3 | Output position select, bit 0 least significant |
| din | input | 1 | Data bit; 1 turns the addressed sink on |
| clr_n | input | 1 | Active-low clear control, one of the two mode inputs |
| en_n | input | 1 | Active-low enable control, one of the two mode inputs |
| sink_on | output | 8 | Driver gate bits, 1 = sink conducting |
| pad_level | output | 8 | Modelled pin level, inverse of `sink_on` |

## Verification
Every mode takes effect exactly one rising edge after its inputs are presented. The bench drives new inputs on the falling edge, lets one rising edge pass, and compares `sink_on` and `pad_level` on the next falling edge against a bench model stepped once per edge. Reset is the only result due with no clock edge: the bench pulls `rst_n` low between edges and samples a nanosecond later. `pad_level` is combinational from the stored bits, so it is checked in the same sample as `sink_on`.

// File: rtl/adl_pkg.sv
package adl_pkg;

    // Mode code is {clr_n, en_n}
    typedef enum logic [1:0] {
        MODE_DEMUX = 2'b00,
        MODE_OFF   = 2'b01,
        MODE_LOAD  = 2'b10,
        MODE_HOLD  = 2'b11
    } adl_mode_t;

endpackage

// File: rtl/adl_mode_dec.sv
module adl_mode_dec
    import adl_pkg::*;
(
    input  logic      clr_n,
    input  logic      en_n,
    output adl_mode_t mode
);
    always_comb begin
        unique case ({clr_n, en_n})
            2'b00:   mode = MODE_DEMUX;
            2'b01:   mode = MODE_OFF;
            2'b10:   mode = MODE_LOAD;
            default: mode = MODE_HOLD;
        endcase
    end
endmodule

// File: rtl/adl_sel_dec.sv
module adl_sel_dec #(
    parameter int N_OUT = 8,
    localparam int SEL_W = $clog2(N_OUT)
) (
    input  logic [SEL_W-1:0] sel,
    output logic [N_OUT-1:0] onehot
);
    for (genvar g = 0; g < N_OUT; g++) begin : g_line
        assign onehot[g] = (sel == SEL_W'(g));
    end
endmodule

// File: rtl/adl_store.sv
module adl_store
    import adl_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  adl_mode_t        mode,
    input  logic [N_OUT-1:0] onehot,
    input  logic             din,
    output logic [N_OUT-1:0] drive
);
    typedef struct packed {
        logic [N_OUT-1:0] drive;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (mode)
            MODE_LOAD:  st_d.drive = (st_q.drive & ~onehot) | (onehot & {N_OUT{din}});
            MODE_HOLD:  st_d.drive = st_q.drive;
            MODE_DEMUX: st_d.drive = onehot & {N_OUT{din}};
            default:    st_d.drive = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drive = st_q.drive;

    assert_others_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |=> (((drive ^ $past(drive)) & ~$past(onehot)) == '0));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(drive));

    assert_all_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> (drive == '0));

    assert_demux_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DEMUX) |=> ($countones(drive) <= 1));
endmodule

// File: rtl/adl_latch8.sv
module adl_latch8
    import adl_pkg::*;
#(
    parameter int N_OUT = 8,
    localparam int SEL_W = $clog2(N_OUT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             din,
    input  logic             clr_n,
    input  logic             en_n,
    output logic [N_OUT-1:0] sink_on,
    output logic [N_OUT-1:0] pad_level
);
    adl_mode_t        mode;
    logic [N_OUT-1:0] onehot;

    adl_mode_dec u_mode (.clr_n(clr_n), .en_n(en_n), .mode(mode));

    adl_sel_dec #(.N_OUT(N_OUT)) u_sel (.sel(sel), .onehot(onehot));

    adl_store #(.N_OUT(N_OUT)) u_store (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .onehot(onehot), .din(din), .drive(sink_on)
    );

    assign pad_level = ~sink_on;

    assert_load_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !en_n) |=> (sink_on[$past(sel)] == $past(din)));

    assert_demux_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !en_n) |=> (sink_on[$past(sel)] == $past(din)));

    assert_pad_inverse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_level ^ sink_on) == '1);
endmodule

// File: tb/adl_latch8_bench.sv
`timescale 1ns/1ps
module adl_latch8_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = '0;
    logic       din = 1'b0;
    logic       clr_n = 1'b1;
    logic       en_n = 1'b1;
    logic [7:0] sink_on, pad_level;
    logic [7:0] exp_q = '0;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    adl_latch8 u_adl_latch8 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .din(din),
        .clr_n(clr_n), .en_n(en_n), .sink_on(sink_on), .pad_level(pad_level)
    );

    function automatic logic [7:0] model_next(logic [7:0] cur, logic [2:0] s,
                                              logic d, logic c, logic e);
        logic [7:0] nx;
        nx = cur;
        case ({c, e})
            2'b10: nx[s] = d;
            2'b11: nx = cur;
            2'b00: begin nx = '0; nx[s] = d; end
            default: nx = '0;
        endcase
        return nx;
    endfunction

    function automatic string mode_req(logic c, logic e);
        case ({c, e})
            2'b10:   return "R2/R3";
            2'b11:   return "R4";
            2'b00:   return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string req);
        checks++;
        if (sink_on !== exp_q) begin
            failures++;
            $display("FAIL %s sink_on actual=%b expected=%b", req, sink_on, exp_q);
        end
        checks++;
        if (pad_level !== ~exp_q) begin
            failures++;
            $display("FAIL R7 pad_level actual=%b expected=%b", pad_level, ~exp_q);
        end
    endtask

    task automatic step(logic [2:0] s, logic d, logic c, logic e, string req);
        sel = s; din = d; clr_n = c; en_n = e;
        @(posedge clk);
        exp_q = model_next(exp_q, s, d, c, e);
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R8");
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: set each position in turn, address k drives bit k
        for (int k = 0; k < 8; k++) step(3'(k), 1'b1, 1'b1, 1'b0, "R1 R2");
        // R3: clear one at a time, others kept
        for (int k = 0; k < 8; k += 2) step(3'(k), 1'b0, 1'b1, 1'b0, "R3");
        // R4: hold while sel/din toggle
        for (int k = 0; k < 8; k++) step(3'(k), k[0], 1'b1, 1'b1, "R4");
        // R6: decoder walk with din high then low
        for (int k = 0; k < 8; k++) step(3'(k), 1'b1, 1'b0, 1'b0, "R1 R6");
        for (int k = 0; k < 8; k++) step(3'(k), 1'b0, 1'b0, 1'b0, "R6");
        // R5 then R9: set pattern, global off, return to hold
        for (int k = 0; k < 8; k++) step(3'(k), 1'b1, 1'b1, 1'b0, "R2");
        step(3'd5, 1'b1, 1'b0, 1'b1, "R5");
        for (int k = 0; k < 4; k++) step(3'(k), 1'b1, 1'b1, 1'b1, "R9");
        // all addresses through all modes
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 8; k++)
                step(3'(k), 1'b1, m[1], m[0], mode_req(m[1], m[0]));
        // random
        for (int i = 0; i < 400; i++) begin
            logic [2:0] s;
            logic d, c, e;
            s = 3'($urandom);
            d = 1'($urandom);
            c = 1'($urandom);
            e = 1'($urandom);
            step(s, d, c, e, mode_req(c, e));
        end
        // R8: async reset between edges
        for (int k = 0; k < 8; k++) step(3'(k), 1'b1, 1'b1, 1'b0, "R2");
        sel = 3'd0; din = 1'b1; clr_n = 1'b1; en_n = 1'b1;
        #1 rst_n = 1'b0;
        exp_q = '0;
        #1 check("R8");
        @(negedge clk);
        check("R8");
        rst_n = 1'b1;
        @(negedge clk);
        step(3'd2, 1'b1, 1'b1, 1'b1, "R4");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule